// File: doc/BRIEF.md
# Package Low-Power State Sequencer

This block follows the power state of a processor package. Four active-low sideband requests drive it: stop-clock, sleep, deep-sleep and deeper-sleep. The package moves one level at a time through Normal, Stop-Grant, Sleep, Deep Sleep and Deeper Sleep. Each level is entered when its own request is asserted and left when that request is released. A request that does not belong to the current level is ignored.

From Stop-Grant the package can take a short detour into a Snoop state to service a snoop request. After a fixed service latency a one-cycle strobe marks completion and the package returns to Stop-Grant. The outputs give the current state as a code, as a one-hot vector and as a clock-enable indication.

The block also reads the C-state reported by each of two cores. It maps each one to a package level and takes the shallowest as the coordinated target. It raises a mismatch flag whenever the package sits deeper than that target.

Top module: `pkg_pwr_seq`

## Requirements
- R1: A synchronous active-high reset puts the package in Normal, with `clk_en` high and `snoop_done` low on the first cycle after reset.
- R2: In Normal, a low `stop_req_n` at a clock edge moves the state to Stop-Grant. In Stop-Grant, a high `stop_req_n` returns it to Normal. Release of the stop request has priority over every other input in Stop-Grant.
- R3: In Stop-Grant, with the stop request still low and no snoop pending, a low `sleep_req_n` moves the state to Sleep. In Sleep, a high `sleep_req_n` returns it to Stop-Grant.
- R4: In Sleep, a low `deep_req_n` moves the state to Deep Sleep. In Deep Sleep, a high `deep_req_n` returns it to Sleep.
- R5: In Deep Sleep, a low `deeper_req_n` moves the state to Deeper Sleep. In Deeper Sleep, a high `deeper_req_n` returns it to Deep Sleep.
- R6: A request that does not belong to the current level leaves the state unchanged. Examples are a deep or deeper request in Stop-Grant, a snoop outside Stop-Grant, and any request other than its own in Deeper Sleep. The state never skips a level.
- R7: In Stop-Grant, with the stop request held low, `snoop_req` high at an edge moves the state to Snoop, and a snoop takes priority over a sleep request. Snoop lasts exactly 4 cycles and ignores all requests. `snoop_done` is high for one cycle, during the last of those cycles, and the state then returns to Stop-Grant.
- R8: `state_code` encodes the state as follows: Normal=0, Stop-Grant=1, Sleep=2, Deep Sleep=3, Deeper Sleep=4, Snoop=5. `state_onehot` has exactly one bit set, the bit at index `state_code`.
- R9: `clk_en` is high in Normal and in Snoop, and low in every other state.
- R10: Each 3-bit core C-state maps to a package level. Codes 0 and 1 (C0/C1) map to Normal, 2 (C2) to Stop-Grant, 3 (C3) to Deep Sleep, and 4 to 7 (C4/C6) to Deeper Sleep. `target_code` uses the R8 state codes and holds the shallower of the two mapped levels.
- R11: `mismatch` is high exactly when the depth of the current state exceeds the depth of `target_code`. Snoop counts at the depth of Stop-Grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep-sleep request, active low |
| deeper_req_n | input | 1 | Deeper-sleep request, active low |
| snoop_req | input | 1 | Snoop request, active high |
| core0_cst | input | 3 | C-state reported by core 0 |
| core1_cst | input | 3 | C-state reported by core 1 |
| state_code | output | 3 | Encoded current state (R8) |
| state_onehot | output | 6 | One-hot current state |
| clk_en | output | 1 | Clock enable indication |
| snoop_done | output | 1 | Snoop service completion strobe |
| target_code | output | 3 | Coordinated target state |
| mismatch | output | 1 | Current state deeper than target |

## Verification
The state register feeds `state_code`, `state_onehot`, `clk_en` and `mismatch` with no further delay. A wrong next-state decision therefore shows at the ports on the cycle after the edge that took it. A miscounted snoop service appears as `snoop_done` arriving too early or too late, and as a Snoop residency other than four cycles. The target coordination is purely combinational, so a mapping error shows on `target_code` and `mismatch` in the same cycle the core states are applied.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_NORMAL  = 3'd0,
        PS_STOPGNT = 3'd1,
        PS_SLEEP   = 3'd2,
        PS_DEEP    = 3'd3,
        PS_DEEPER  = 3'd4,
        PS_SNOOP   = 3'd5
    } pstate_e;

    localparam int NSTATE   = 6;
    localparam int CST_W    = 3;
    localparam int SNOOP_LAT = 4;

    // Requests after conversion to active-high
    typedef struct packed {
        logic stop;
        logic sleep;
        logic deep;
        logic deeper;
        logic snoop;
    } req_t;

    function automatic pstate_e cstate_level(input logic [CST_W-1:0] c);
        pstate_e r;
        if (c <= 3'd1)      r = PS_NORMAL;
        else if (c == 3'd2) r = PS_STOPGNT;
        else if (c == 3'd3) r = PS_DEEP;
        else                r = PS_DEEPER;
        return r;
    endfunction

    function automatic logic [2:0] depth_of(input pstate_e s);
        return (s == PS_SNOOP) ? 3'd1 : 3'(s);
    endfunction

endpackage

// File: rtl/pwr_target_merge.sv
module pwr_target_merge
    import pwrseq_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic [NCORES-1:0][CST_W-1:0] cst,
    output pstate_e                      target
);
    pstate_e lvl [NCORES];

    for (genvar i = 0; i < NCORES; i++) begin : g_map
        assign lvl[i] = cstate_level(cst[i]);
    end

    always_comb begin
        target = lvl[0];
        for (int i = 1; i < NCORES; i++) begin
            if (depth_of(lvl[i]) < depth_of(target))
                target = lvl[i];
        end
    end
endmodule

// File: rtl/pwr_snoop_timer.sv
module pwr_snoop_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt;

    assign done = active && (cnt == CW'(LAT - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || done) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwrseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  req_t    req,
    input  logic    svc_done,
    output pstate_e state
);
    pstate_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_NORMAL:  if (req.stop) nxt = PS_STOPGNT;
            PS_STOPGNT: begin
                if (!req.stop)      nxt = PS_NORMAL;
                else if (req.snoop) nxt = PS_SNOOP;
                else if (req.sleep) nxt = PS_SLEEP;
            end
            PS_SNOOP:   if (svc_done) nxt = PS_STOPGNT;
            PS_SLEEP: begin
                if (!req.sleep)     nxt = PS_STOPGNT;
                else if (req.deep)  nxt = PS_DEEP;
            end
            PS_DEEP: begin
                if (!req.deep)       nxt = PS_SLEEP;
                else if (req.deeper) nxt = PS_DEEPER;
            end
            PS_DEEPER:  if (!req.deeper) nxt = PS_DEEP;
            default:    nxt = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_NORMAL;
        else     state <= nxt;
    end
endmodule

// File: rtl/pkg_pwr_seq.sv
module pkg_pwr_seq
    import pwrseq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stop_req_n,
    input  logic                    sleep_req_n,
    input  logic                    deep_req_n,
    input  logic                    deeper_req_n,
    input  logic                    snoop_req,
    input  logic [2:0]              core0_cst,
    input  logic [2:0]              core1_cst,
    output logic [2:0]              state_code,
    output logic [NSTATE-1:0]       state_onehot,
    output logic                    clk_en,
    output logic                    snoop_done,
    output logic [2:0]              target_code,
    output logic                    mismatch
);
    req_t    req;
    pstate_e state;
    pstate_e target;

    assign req = '{stop:   !stop_req_n,
                   sleep:  !sleep_req_n,
                   deep:   !deep_req_n,
                   deeper: !deeper_req_n,
                   snoop:  snoop_req};

    pwr_snoop_timer #(.LAT(SNOOP_LAT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (state == PS_SNOOP),
        .done   (snoop_done)
    );

    pwr_state_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .svc_done (snoop_done),
        .state    (state)
    );

    pwr_target_merge #(.NCORES(2)) u_merge (
        .cst    ({core1_cst, core0_cst}),
        .target (target)
    );

    for (genvar i = 0; i < NSTATE; i++) begin : g_onehot
        assign state_onehot[i] = (state == pstate_e'(3'(i)));
    end

    assign state_code  = state;
    assign target_code = target;
    assign clk_en      = (state == PS_NORMAL) || (state == PS_SNOOP);
    assign mismatch    = depth_of(state) > depth_of(target);
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req_n,
    input logic       deep_req_n,
    input logic [2:0] core0_cst,
    input logic [2:0] core1_cst,
    input logic [2:0] state_code,
    input logic [5:0] state_onehot,
    input logic       clk_en,
    input logic       snoop_done,
    input logic [2:0] target_code,
    input logic       mismatch
);
    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_onehot) == 1) && ((state_onehot & (6'b1 << state_code)) != 6'b0));

    assert_normal_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0) |=> (state_code == 3'd0 || state_code == 3'd1));

    assert_stopgnt_noskip_R6: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1) |=> (state_code != 3'd3 && state_code != 3'd4));

    assert_sleep_stay_R3: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && !sleep_req_n && deep_req_n) |=> (state_code == 3'd2));

    assert_deep_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && deep_req_n) |=> (state_code != 3'd3));

    assert_snoop_in_state_R7: assert property (@(posedge clk) disable iff (rst)
        snoop_done |-> state_onehot[5]);

    assert_snoop_exit_R7: assert property (@(posedge clk) disable iff (rst)
        snoop_done |=> (state_code == 3'd1 && !snoop_done));

    assert_clken_low_R9: assert property (@(posedge clk) disable iff (rst)
        (state_onehot[1] || state_onehot[2] || state_onehot[3] || state_onehot[4]) |-> !clk_en);

    assert_target_shallow_R10: assert property (@(posedge clk) disable iff (rst)
        (core0_cst <= 3'd1 || core1_cst <= 3'd1) |-> (target_code == 3'd0));

    assert_mismatch_normal_R11: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0) |-> !mismatch);

    assert_mismatch_deep_R11: assert property (@(posedge clk) disable iff (rst)
        (target_code == 3'd0 && state_code != 3'd0) |-> mismatch);
endmodule

bind pkg_pwr_seq pwrseq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_req_n  (sleep_req_n),
    .deep_req_n   (deep_req_n),
    .core0_cst    (core0_cst),
    .core1_cst    (core1_cst),
    .state_code   (state_code),
    .state_onehot (state_onehot),
    .clk_en       (clk_en),
    .snoop_done   (snoop_done),
    .target_code  (target_code),
    .mismatch     (mismatch)
);

// File: tb/sim_pkg_pwr_seq.sv
`timescale 1ns/1ps
module sim_pkg_pwr_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1, deeper_n = 1'b1;
    logic       snoop = 1'b0;
    logic [2:0] c0 = 3'd0, c1 = 3'd0;
    logic [2:0] state_code, target_code;
    logic [5:0] state_onehot;
    logic       clk_en, snoop_done, mismatch;

    int total = 0;
    int failed = 0;
    int m_s = 0;
    int m_c = 0;

    always #2 clk = ~clk;

    pkg_pwr_seq u0 (
        .clk(clk), .rst(rst),
        .stop_req_n(stop_n), .sleep_req_n(sleep_n),
        .deep_req_n(deep_n), .deeper_req_n(deeper_n),
        .snoop_req(snoop), .core0_cst(c0), .core1_cst(c1),
        .state_code(state_code), .state_onehot(state_onehot),
        .clk_en(clk_en), .snoop_done(snoop_done),
        .target_code(target_code), .mismatch(mismatch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl_of(input int c);
        if (c <= 1) return 0;
        if (c == 2) return 1;
        if (c == 3) return 3;
        return 4;
    endfunction

    // Advance the reference by one edge using the requirement rules
    task automatic cyc(input string tag);
        int ns = m_s;
        int nc = 0;
        int tg;
        int dep;
        if (rst) begin
            ns = 0;
        end else begin
            case (m_s)
                0: if (!stop_n) ns = 1;
                1: begin
                    if (stop_n)       ns = 0;
                    else if (snoop)   ns = 5;
                    else if (!sleep_n) ns = 2;
                end
                5: if (m_c == 3) ns = 1; else nc = m_c + 1;
                2: begin
                    if (sleep_n)     ns = 1;
                    else if (!deep_n) ns = 3;
                end
                3: begin
                    if (deep_n)        ns = 2;
                    else if (!deeper_n) ns = 4;
                end
                4: if (deeper_n) ns = 3;
                default: ns = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        m_s = ns;
        m_c = nc;
        tg  = (lvl_of(int'(c0)) < lvl_of(int'(c1))) ? lvl_of(int'(c0)) : lvl_of(int'(c1));
        dep = (m_s == 5) ? 1 : m_s;
        chk({tag, " state"}, int'(state_code), m_s);
        chk("R8 onehot", int'(state_onehot), 1 << m_s);
        chk("R9 clk_en", int'(clk_en), (m_s == 0 || m_s == 5) ? 1 : 0);
        chk("R7 snoop_done", int'(snoop_done), (m_s == 5 && m_c == 3) ? 1 : 0);
        chk("R10 target", int'(target_code), tg);
        chk("R11 mismatch", int'(mismatch), (dep > tg) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [15:0] l;
        // R1: reset state
        cyc("R1"); cyc("R1");
        rst = 1'b0;
        cyc("R1");
        // R2: Normal <-> Stop-Grant
        stop_n = 1'b0; cyc("R2");
        stop_n = 1'b1; cyc("R2");
        stop_n = 1'b0; cyc("R2");
        // R6: out-of-order requests in Stop-Grant
        deep_n = 1'b0; deeper_n = 1'b0; cyc("R6"); cyc("R6");
        deep_n = 1'b1; deeper_n = 1'b1;
        // R3: Stop-Grant -> Sleep
        sleep_n = 1'b0; cyc("R3");
        // R6: deeper request in Sleep, snoop in Sleep
        deeper_n = 1'b0; snoop = 1'b1; cyc("R6");
        deeper_n = 1'b1; snoop = 1'b0;
        // R4 / R5 descend
        deep_n = 1'b0; cyc("R4");
        deeper_n = 1'b0; cyc("R5");
        // R6: other requests released in Deeper Sleep
        deep_n = 1'b1; sleep_n = 1'b1; stop_n = 1'b1; snoop = 1'b1; cyc("R6"); cyc("R6");
        stop_n = 1'b0; sleep_n = 1'b0; deep_n = 1'b0; snoop = 1'b0;
        // R10 / R11: core sweep while in Deeper Sleep
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                c0 = 3'(a); c1 = 3'(b); cyc("R10");
            end
        c0 = 3'd0; c1 = 3'd0;
        // ascend: R5, R4, R3
        deeper_n = 1'b1; cyc("R5");
        deep_n = 1'b1; cyc("R4");
        sleep_n = 1'b1; cyc("R3");
        // R7: snoop detour, requests ignored during it
        snoop = 1'b1; sleep_n = 1'b0; cyc("R7");
        snoop = 1'b0; stop_n = 1'b1;
        cyc("R7"); cyc("R7"); cyc("R7"); cyc("R7");
        // R2: stop release beats snoop
        snoop = 1'b1; cyc("R2");
        snoop = 1'b0; sleep_n = 1'b1;
        // R10 / R11: core sweep in Normal
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                c0 = 3'(a); c1 = 3'(b); cyc("R11");
            end
        // pseudo-random request mix checked against the reference
        l = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
            stop_n   = (l[3:0] == 4'd0);
            sleep_n  = (l[6:4] == 3'd0);
            deep_n   = (l[8:7] == 2'd0);
            deeper_n = l[9] & l[10];
            snoop    = l[11] & l[12];
            c0 = l[15:13];
            c1 = l[2:0];
            cyc("R6");
        end
        // R1: reset from a deep state
        stop_n = 1'b0; sleep_n = 1'b0; deep_n = 1'b0; deeper_n = 1'b0; snoop = 1'b0;
        repeat (5) cyc("R5");
        rst = 1'b1; cyc("R1");
        rst = 1'b0; stop_n = 1'b1; cyc("R1");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule